// File: doc/BRIEF.md
# Operand-Capturing Reservation Station Bank

This block holds a small number of waiting operations for one functional-unit class. An upstream issue stage hands it an operation code, a destination tag, and two sources. Each source comes either as a finished value (tag zero) or as the tag of the operation that will produce it. While a source is still pending, its entry watches the shared result broadcast bus. When the broadcast tag matches the pending producer tag, the entry copies the broadcast value into its own storage. Operands therefore never have to be read back from a central register file.

Once both sources of an entry hold values, the entry can be offered to the functional unit. When several entries qualify, the one issued earliest goes first. After dispatch the entry stays occupied until the unit broadcasts a result carrying that entry's destination tag, and then it becomes free. A flush input empties the whole bank at once.

Issue and dispatch are valid/ready streams. On the issue side, a transfer happens on a cycle where `iss_valid` and `iss_ready` are both high. If `iss_ready` is low, the upstream stage must stall and keep its request. On the dispatch side, while `disp_valid` is high and `disp_ready` is low, the bank keeps offering the same operation with unchanged fields. The broadcast bus cannot be stalled, and `flush` is a plain control pin.

Top module: `rs_bank`

## Requirements
- R1: After reset, `iss_ready` is 1 and `disp_valid` is 0.
- R2: `iss_ready` is high exactly when at least one entry is free and `flush` is low. An issue request made while `iss_ready` is low leaves the bank unchanged. An entry freed by a broadcast can accept a new issue only from the following cycle.
- R3: A source issued with tag 0 counts as ready at once and holds the value supplied with the issue.
- R4: A pending source whose tag equals `bc_tag` while `bc_valid` is high stores `bc_data` at that clock edge. It counts as ready from the next cycle on.
- R5: If a broadcast matches a source tag in the same cycle that source is issued, the source takes `bc_data` and is ready in the next cycle.
- R6: `disp_valid` is high only when some waiting entry has both sources ready and `flush` is low. `disp_op`, `disp_opnd_a`, `disp_opnd_b` and `disp_dst` then show that entry's operation code, first source value, second source value and destination tag.
- R7: Among waiting entries with both sources ready, the one issued earliest is offered first. At most one entry is dispatched per cycle. While the offer stalls (`disp_ready` low), the same entry stays offered with stable fields.
- R8: A dispatched entry stays occupied until a broadcast with `bc_valid` high and `bc_tag` equal to its destination tag. It is free from the next cycle on.
- R9: `flush` high drives `iss_ready` and `disp_valid` low in that cycle and frees every entry at the clock edge. Any issue or dispatch in that cycle is discarded.
- R10: An entry that has been dispatched is never offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the whole bank |
| iss_valid | input | 1 | Issue request present |
| iss_ready | output | 1 | A free entry can take the issue |
| iss_op | input | OP_W | Operation code |
| iss_tag_a | input | TAG_W | Producer tag of first source, 0 = value supplied |
| iss_val_a | input | DATA_W | Value of first source |
| iss_tag_b | input | TAG_W | Producer tag of second source, 0 = value supplied |
| iss_val_b | input | DATA_W | Value of second source |
| iss_dst | input | TAG_W | Tag the result of this operation will carry (nonzero) |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcast result (nonzero) |
| bc_data | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready operation is offered |
| disp_ready | input | 1 | Functional unit accepts the offer |
| disp_op | output | OP_W | Offered operation code |
| disp_opnd_a | output | DATA_W | Offered first operand |
| disp_opnd_b | output | DATA_W | Offered second operand |
| disp_dst | output | TAG_W | Destination tag of offered operation |

## Verification
The hardest case to reach is the one where a broadcast lands in exactly the cycle its consumer is issued. A close second is an older entry waking up while a younger one is stalled on the dispatch port, since the stalled offer must not change. The stimulus reaches both by drawing producer tags and destination tags from a pool of only five values. Half of all broadcasts are aimed at the destination tag of an entry already dispatched. Dispatch back-pressure is varied over several phases, so offers often stall for many cycles while broadcasts keep arriving.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    PH_FREE = 2'd0,
    PH_WAIT = 2'd1,
    PH_EXEC = 2'd2
  } rs_phase_e;

  localparam int SRC_CNT = 2;
endpackage

// File: rtl/rs_src_slot.sv
module rs_src_slot #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              bus_vld,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              rdy,
  output logic [TAG_W-1:0]  tag,
  output logic [DATA_W-1:0] val
);
  logic ld_hit;
  logic snoop_hit;

  assign ld_hit    = bus_vld && (bus_tag == ld_tag);
  assign snoop_hit = bus_vld && !rdy && (bus_tag == tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy <= 1'b1;
      tag <= '0;
      val <= '0;
    end else if (load) begin
      tag <= ld_tag;
      if (ld_tag == '0) begin
        rdy <= 1'b1;
        val <= ld_val;
      end else if (ld_hit) begin
        rdy <= 1'b1;
        val <= bus_data;
      end else begin
        rdy <= 1'b0;
      end
    end else if (snoop_hit) begin
      rdy <= 1'b1;
      val <= bus_data;
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             flush,
  input  logic                             alloc,
  input  logic                             grant,
  input  logic [OP_W-1:0]                  in_op,
  input  logic [TAG_W-1:0]                 in_dst,
  input  logic [SRC_CNT-1:0][TAG_W-1:0]    in_tag,
  input  logic [SRC_CNT-1:0][DATA_W-1:0]   in_val,
  input  logic                             bus_vld,
  input  logic [TAG_W-1:0]                 bus_tag,
  input  logic [DATA_W-1:0]                bus_data,
  output logic                             busy,
  output logic                             elig,
  output logic [SRC_CNT-1:0]               src_rdy,
  output logic [SRC_CNT-1:0][TAG_W-1:0]    src_tag,
  output logic [SRC_CNT-1:0][DATA_W-1:0]   src_val,
  output logic [OP_W-1:0]                  op,
  output logic [TAG_W-1:0]                 dst
);
  rs_phase_e phase;

  for (genvar s = 0; s < SRC_CNT; s++) begin : g_src
    rs_src_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (alloc),
      .ld_tag   (in_tag[s]),
      .ld_val   (in_val[s]),
      .bus_vld  (bus_vld),
      .bus_tag  (bus_tag),
      .bus_data (bus_data),
      .rdy      (src_rdy[s]),
      .tag      (src_tag[s]),
      .val      (src_val[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      phase <= PH_FREE;
    end else begin
      case (phase)
        PH_FREE: if (alloc) phase <= PH_WAIT;
        PH_WAIT: if (grant) phase <= PH_EXEC;
        PH_EXEC: if (bus_vld && bus_tag == dst) phase <= PH_FREE;
        default: phase <= PH_FREE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op  <= '0;
      dst <= '0;
    end else if (alloc) begin
      op  <= in_op;
      dst <= in_dst;
    end
  end

  assign busy = (phase != PH_FREE);
  assign elig = (phase == PH_WAIT) && (&src_rdy);
endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_oh,
  input  logic [N-1:0] elig,
  output logic [N-1:0] pick_oh
);
  // older[i][j] set: entry i was allocated before entry j
  logic [N-1:0][N-1:0] older;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (i != j) begin
            if (alloc_oh[i])      older[i][j] <= 1'b0;
            else if (alloc_oh[j]) older[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && elig[j] && older[j][i]) blocked = 1'b1;
      end
      pick_oh[i] = elig[i] && !blocked;
    end
  end
endmodule

// File: rtl/rs_bank.sv
module rs_bank
  import rs_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int OP_W    = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_tag_a,
  input  logic [DATA_W-1:0] iss_val_a,
  input  logic [TAG_W-1:0]  iss_tag_b,
  input  logic [DATA_W-1:0] iss_val_b,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_opnd_a,
  output logic [DATA_W-1:0] disp_opnd_b,
  output logic [TAG_W-1:0]  disp_dst
);
  logic [ENTRIES-1:0]                            ent_busy;
  logic [ENTRIES-1:0]                            ent_elig;
  logic [ENTRIES-1:0][SRC_CNT-1:0]               ent_rdy;
  logic [ENTRIES-1:0][SRC_CNT-1:0][TAG_W-1:0]    ent_tag;
  logic [ENTRIES-1:0][SRC_CNT-1:0][DATA_W-1:0]   ent_val;
  logic [ENTRIES-1:0][OP_W-1:0]                  ent_op;
  logic [ENTRIES-1:0][TAG_W-1:0]                 ent_dst;

  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] low_free;
  logic [ENTRIES-1:0] alloc_oh;
  logic [ENTRIES-1:0] pick_oh;
  logic [ENTRIES-1:0] sel_oh;
  logic [ENTRIES-1:0] grant_oh;
  logic               hold_q;
  logic [ENTRIES-1:0] hold_oh_q;

  logic [SRC_CNT-1:0][TAG_W-1:0]  iss_tags;
  logic [SRC_CNT-1:0][DATA_W-1:0] iss_vals;

  assign iss_tags = {iss_tag_b, iss_tag_a};
  assign iss_vals = {iss_val_b, iss_val_a};

  // Issue side: lowest-index free entry takes the operation
  assign free_vec  = ~ent_busy;
  assign low_free  = free_vec & (~free_vec + 1'b1);
  assign iss_ready = (|free_vec) && !flush;
  assign alloc_oh  = (iss_valid && iss_ready) ? low_free : '0;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    rs_entry #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) ent_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .alloc    (alloc_oh[e]),
      .grant    (grant_oh[e]),
      .in_op    (iss_op),
      .in_dst   (iss_dst),
      .in_tag   (iss_tags),
      .in_val   (iss_vals),
      .bus_vld  (bc_valid),
      .bus_tag  (bc_tag),
      .bus_data (bc_data),
      .busy     (ent_busy[e]),
      .elig     (ent_elig[e]),
      .src_rdy  (ent_rdy[e]),
      .src_tag  (ent_tag[e]),
      .src_val  (ent_val[e]),
      .op       (ent_op[e]),
      .dst      (ent_dst[e])
    );
  end

  rs_age_pick #(.N(ENTRIES)) age_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_oh (alloc_oh),
    .elig     (ent_elig),
    .pick_oh  (pick_oh)
  );

  // Dispatch side: a stalled offer is pinned until accepted or flushed
  assign sel_oh     = hold_q ? hold_oh_q : pick_oh;
  assign disp_valid = (|sel_oh) && !flush;
  assign grant_oh   = (disp_valid && disp_ready) ? sel_oh : '0;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      hold_q    <= 1'b0;
      hold_oh_q <= '0;
    end else begin
      hold_q    <= disp_valid && !disp_ready;
      hold_oh_q <= sel_oh;
    end
  end

  always_comb begin
    disp_op     = '0;
    disp_opnd_a = '0;
    disp_opnd_b = '0;
    disp_dst    = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (sel_oh[e]) begin
        disp_op     = disp_op     | ent_op[e];
        disp_opnd_a = disp_opnd_a | ent_val[e][0];
        disp_opnd_b = disp_opnd_b | ent_val[e][1];
        disp_dst    = disp_dst    | ent_dst[e];
      end
    end
  end
endmodule

// File: rtl/rs_bank_chk.sv
module rs_bank_chk #(
  parameter int N      = 4,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        flush,
  input logic                        iss_ready,
  input logic                        disp_valid,
  input logic                        disp_ready,
  input logic [OP_W-1:0]             disp_op,
  input logic [DATA_W-1:0]           disp_opnd_a,
  input logic [DATA_W-1:0]           disp_opnd_b,
  input logic [TAG_W-1:0]            disp_dst,
  input logic                        bc_valid,
  input logic [TAG_W-1:0]            bc_tag,
  input logic [N-1:0]                sel_oh,
  input logic [N-1:0]                ent_elig,
  input logic [N-1:0]                ent_busy,
  input logic [N-1:0][1:0]           ent_rdy,
  input logic [N-1:0][1:0][TAG_W-1:0] ent_tag
);
  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (flush || (iss_ready && !disp_valid)));

  // R7
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (flush || (disp_valid && $stable(disp_op) &&
      $stable(disp_opnd_a) && $stable(disp_opnd_b) && $stable(disp_dst))));

  // R6
  single_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> ($countones(sel_oh) == 1 && (sel_oh & ~ent_elig) == '0));

  for (genvar e = 0; e < N; e++) begin : g_wake
    for (genvar s = 0; s < 2; s++) begin : g_src
      // R4
      no_stale_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && !flush) |=>
          !(ent_busy[e] && !ent_rdy[e][s] && ent_tag[e][s] == $past(bc_tag)));
    end
  end
endmodule

bind rs_bank rs_bank_chk #(
  .N(ENTRIES), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .iss_ready   (iss_ready),
  .disp_valid  (disp_valid),
  .disp_ready  (disp_ready),
  .disp_op     (disp_op),
  .disp_opnd_a (disp_opnd_a),
  .disp_opnd_b (disp_opnd_b),
  .disp_dst    (disp_dst),
  .bc_valid    (bc_valid),
  .bc_tag      (bc_tag),
  .sel_oh      (sel_oh),
  .ent_elig    (ent_elig),
  .ent_busy    (ent_busy),
  .ent_rdy     (ent_rdy),
  .ent_tag     (ent_tag)
);

// File: tb/rs_bank_tb_top.sv
module rs_bank_tb_top;
  localparam int N      = 4;
  localparam int OP_W   = 4;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              iss_valid = 1'b0;
  logic              iss_ready;
  logic [OP_W-1:0]   iss_op = '0;
  logic [TAG_W-1:0]  iss_tag_a = '0;
  logic [DATA_W-1:0] iss_val_a = '0;
  logic [TAG_W-1:0]  iss_tag_b = '0;
  logic [DATA_W-1:0] iss_val_b = '0;
  logic [TAG_W-1:0]  iss_dst = '0;
  logic              bc_valid = 1'b0;
  logic [TAG_W-1:0]  bc_tag = '0;
  logic [DATA_W-1:0] bc_data = '0;
  logic              disp_valid;
  logic              disp_ready = 1'b0;
  logic [OP_W-1:0]   disp_op;
  logic [DATA_W-1:0] disp_opnd_a;
  logic [DATA_W-1:0] disp_opnd_b;
  logic [TAG_W-1:0]  disp_dst;

  always #5 clk = ~clk;

  rs_bank #(.ENTRIES(N), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_tag_a(iss_tag_a), .iss_val_a(iss_val_a),
    .iss_tag_b(iss_tag_b), .iss_val_b(iss_val_b), .iss_dst(iss_dst),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_opnd_a(disp_opnd_a), .disp_opnd_b(disp_opnd_b), .disp_dst(disp_dst)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // Reference model: plain arrays plus an issue sequence number per slot
  bit m_busy [N];
  bit m_exec [N];
  bit m_rdy  [N][2];
  int m_tag  [N][2];
  int m_val  [N][2];
  int m_op   [N];
  int m_dst  [N];
  int m_seq  [N];
  int seq_ctr = 0;
  int m_hold = -1;
  bit exp_ir;
  int exp_sel;
  bit exp_dv;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int oldest_ready();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (m_busy[i] && !m_exec[i] && m_rdy[i][0] && m_rdy[i][1])
        if (best < 0 || m_seq[i] < m_seq[best]) best = i;
    return best;
  endfunction

  function automatic bit chance(input int pct);
    return ($urandom_range(99) < pct);
  endfunction

  function automatic int pick_src_tag();
    if (chance(40)) return 0;
    return $urandom_range(5, 1);
  endfunction

  task automatic compare_outputs();
    bit has_free = 1'b0;
    for (int i = 0; i < N; i++) if (!m_busy[i]) has_free = 1'b1;
    exp_ir  = has_free && !flush;
    exp_sel = (m_hold >= 0) ? m_hold : oldest_ready();
    exp_dv  = (exp_sel >= 0) && !flush;
    // R2 R9: issue readiness
    chk(iss_ready == exp_ir, "R2 iss_ready", iss_ready, exp_ir);
    // R6 R8 R10 R9: dispatch offer present
    chk(disp_valid == exp_dv, "R6 disp_valid", disp_valid, exp_dv);
    if (exp_dv && disp_valid) begin
      longint act_w, exp_w;
      act_w = {disp_op, disp_dst, disp_opnd_a, disp_opnd_b};
      exp_w = {m_op[exp_sel][OP_W-1:0], m_dst[exp_sel][TAG_W-1:0],
               m_val[exp_sel][0][DATA_W-1:0], m_val[exp_sel][1][DATA_W-1:0]};
      // R3 R4 R5 R7: operands, order and held offer
      chk(act_w == exp_w, "R7 dispatch fields (R3 R4 R5 values)", act_w, exp_w);
    end
  endtask

  task automatic model_update();
    int a = -1;
    int s = exp_sel;
    if (exp_ir && iss_valid)
      for (int i = N - 1; i >= 0; i--) if (!m_busy[i]) a = i;
    if (flush) begin
      for (int i = 0; i < N; i++) begin
        m_busy[i] = 1'b0;
        m_exec[i] = 1'b0;
      end
      m_hold = -1;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (!m_busy[i]) continue;
        if (m_exec[i]) begin
          if (bc_valid && m_dst[i] == int'(bc_tag)) begin
            m_busy[i] = 1'b0;
            m_exec[i] = 1'b0;
          end
        end else begin
          for (int k = 0; k < 2; k++)
            if (!m_rdy[i][k] && bc_valid && m_tag[i][k] == int'(bc_tag)) begin
              m_rdy[i][k] = 1'b1;
              m_val[i][k] = int'(bc_data);
            end
        end
      end
      if (exp_dv) begin
        if (disp_ready) begin
          m_exec[s] = 1'b1;
          m_hold = -1;
        end else begin
          m_hold = s;
        end
      end else begin
        m_hold = -1;
      end
      if (a >= 0) begin
        m_busy[a] = 1'b1;
        m_exec[a] = 1'b0;
        m_op[a]   = int'(iss_op);
        m_dst[a]  = int'(iss_dst);
        m_seq[a]  = seq_ctr;
        seq_ctr++;
        m_tag[a][0] = int'(iss_tag_a);
        m_tag[a][1] = int'(iss_tag_b);
        for (int k = 0; k < 2; k++) begin
          int v = (k == 0) ? int'(iss_val_a) : int'(iss_val_b);
          if (m_tag[a][k] == 0) begin
            m_rdy[a][k] = 1'b1;
            m_val[a][k] = v;
          end else if (bc_valid && m_tag[a][k] == int'(bc_tag)) begin
            m_rdy[a][k] = 1'b1;
            m_val[a][k] = int'(bc_data);
          end else begin
            m_rdy[a][k] = 1'b0;
          end
        end
      end
    end
  endtask

  task automatic run_cycle(input int p_iss, input int p_bc, input int p_rdy, input int p_fl);
    @(negedge clk);
    iss_valid = chance(p_iss);
    iss_op    = OP_W'($urandom_range(15));
    iss_tag_a = TAG_W'(pick_src_tag());
    iss_tag_b = TAG_W'(pick_src_tag());
    iss_val_a = DATA_W'($urandom_range(65535));
    iss_val_b = DATA_W'($urandom_range(65535));
    iss_dst   = TAG_W'($urandom_range(5, 1));
    bc_valid  = chance(p_bc);
    bc_data   = DATA_W'($urandom_range(65535));
    bc_tag    = TAG_W'($urandom_range(5, 1));
    if (chance(50))
      for (int i = 0; i < N; i++)
        if (m_busy[i] && m_exec[i]) bc_tag = TAG_W'(m_dst[i]);
    disp_ready = chance(p_rdy);
    flush      = chance(p_fl);
    #1;
    compare_outputs();
    @(posedge clk);
    model_update();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(iss_ready == 1'b1, "R1 iss_ready after reset", iss_ready, 1);
    chk(disp_valid == 1'b0, "R1 disp_valid after reset", disp_valid, 0);
    repeat (1500) run_cycle(70, 40, 80, 0);
    repeat (1500) run_cycle(90, 30, 20, 1);
    repeat (1500) run_cycle(50, 70, 60, 2);
    repeat (500)  run_cycle(100, 10, 100, 0);
    repeat (500)  run_cycle(95, 60, 5, 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule